// File: doc/BRIEF.md
# Lock-Step Pairwise Summation Engine

This block adds up a vector of N unsigned words. Internally, N lanes share one register array and all advance on the same clock. Each lane performs at most one action per step. When a start pulse arrives while the engine is idle, every lane copies its own input word into its own slot of the shared array. The lanes then run log2(N) halving rounds. In each round, lane i (counting from 0) overwrites slot i with the sum of slots 2i and 2i+1. Only lanes below N/2^h take part in round h. All other slots keep their contents. Every read in a round sees the values left by the previous round. After the last round, slot 0 holds the complete sum. In one final step, a single writer copies that slot into the total register and flags completion.

The whole job takes 2 + log2(N) clock steps: one load step, the halving rounds, and one store step. The result is widened by log2(N) bits, so the sum of N maximal words is never truncated. The requester drives a vector and a one-cycle start, then waits for the done pulse and reads the total. N must be a power of two, and N and the word width are parameters.

Top module: `tree_sum_engine`

## Requirements
- R1: While reset is asserted and after its release, busy_o and done_o are 0 and total_o is 0 until the first job completes.
- R2: The input vector is sampled only at the rising edge where start_i is accepted. Changing vec_i afterwards has no effect on that job's total.
- R3: The total equals the exact unsigned sum of the N words of vec_i (word k in bits k*DATA_W upward), carried in DATA_W+log2(N) bits, so N all-ones words sum without loss.
- R4: Number the edge that accepts start_i as edge 1. done_o is then high for exactly one cycle, the cycle after edge 2+log2(N).
- R5: busy_o is high from the edge that accepts start_i up to the store edge, which is log2(N)+1 cycles. It is low otherwise.
- R6: A start_i that arrives while busy_o is high is ignored: the running job keeps its timing and its result, and no second job follows.
- R7: total_o changes only at the store edge, so it holds its value between jobs and for the whole of a running job.
- R8: A start_i given in the cycle where done_o is high is accepted, so jobs can run back to back with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all lanes |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse; accepted only while idle |
| vec_i | input | N*DATA_W | Packed input words, word k in bits k*DATA_W +: DATA_W |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse, aligned with the new total |
| total_o | output | DATA_W+log2(N) | Sum of the last completed job |

## Verification
The hardest situations to reach from the ports are the ones where a job's inputs and a new request collide with a running job. These are a start that arrives in the middle of the halving rounds, a vector that changes right after it is sampled, and a new start in the very cycle that done_o pulses. The stimulus creates these on purpose. It raises start_i again for several cycles mid-job and loads a different vector at the same time. It rewrites vec_i right after acceptance. It issues the next job from the cycle where done_o is observed high. A behavioural per-cycle model then shows whether any of these leaked into the timing or the total. All-ones vectors drive the widened carry to its limit.

// File: rtl/tsum_pkg.sv
package tsum_pkg;

    // Sequencer phases of one summation job
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_REDUCE = 2'd1,
        PH_STORE  = 2'd2
    } phase_e;

endpackage

// File: rtl/tsum_sequencer.sv
module tsum_sequencer
    import tsum_pkg::*;
#(
    parameter int N     = 8,
    parameter int LOG_N = $clog2(N),
    parameter int RND_W = $clog2(LOG_N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    output logic         load_o,
    output logic [N-1:0] lane_en_o,
    output logic         store_o,
    output logic         busy_o
);

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(LOG_N);
    localparam logic [RND_W-1:0] FIRST_RND = RND_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [RND_W-1:0]  round;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        load_o  = 1'b0;
        store_o = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load_o      = 1'b1;
                    seq_d.phase = PH_REDUCE;
                    seq_d.round = FIRST_RND;
                end
            end
            PH_REDUCE: begin
                if (seq_q.round == LAST_RND) begin
                    seq_d.phase = PH_STORE;
                end else begin
                    seq_d.round = seq_q.round + FIRST_RND;
                end
            end
            PH_STORE: begin
                store_o     = 1'b1;
                seq_d.phase = PH_IDLE;
                seq_d.round = '0;
            end
            default: begin
                seq_d.phase = PH_IDLE;
                seq_d.round = '0;
            end
        endcase
    end

    // Lane j works in round h only when j < N / 2^h
    always_comb begin
        for (int j = 0; j < N; j++) begin
            lane_en_o[j] = (seq_q.phase == PH_REDUCE) && (j < (N >> seq_q.round));
        end
    end

    assign busy_o = (seq_q.phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, round: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/tsum_lane.sv
module tsum_lane #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              add_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [ACC_W-1:0]  left_i,
    input  logic [ACC_W-1:0]  right_i,
    output logic [ACC_W-1:0]  slot_o
);

    localparam int PAD_W = ACC_W - DATA_W;

    logic [ACC_W-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load_i) begin
            slot_d = {{PAD_W{1'b0}}, word_i};
        end else if (add_i) begin
            slot_d = left_i + right_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/tsum_store.sv
module tsum_store #(
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_i,
    input  logic [ACC_W-1:0] head_i,
    output logic [ACC_W-1:0] total_o,
    output logic             done_o
);

    typedef struct packed {
        logic [ACC_W-1:0] total;
        logic             done;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.done = 1'b0;
        if (store_i) begin
            out_d.total = head_i;
            out_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign total_o = out_q.total;
    assign done_o  = out_q.done;

endmodule

// File: rtl/tree_sum_engine.sv
module tree_sum_engine #(
    parameter int N      = 8,
    parameter int DATA_W = 16,
    parameter int LOG_N  = $clog2(N),
    parameter int ACC_W  = DATA_W + LOG_N
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [N*DATA_W-1:0] vec_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [ACC_W-1:0]    total_o
);

    logic             load;
    logic             store;
    logic [N-1:0]     lane_en;
    logic [ACC_W-1:0] slot [N];

    tsum_sequencer #(
        .N     (N),
        .LOG_N (LOG_N)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .load_o    (load),
        .lane_en_o (lane_en),
        .store_o   (store),
        .busy_o    (busy_o)
    );

    for (genvar j = 0; j < N; j++) begin : g_lane
        logic [ACC_W-1:0] left, right;
        if (2*j + 1 < N) begin : g_pair
            assign left  = slot[2*j];
            assign right = slot[2*j+1];
        end else begin : g_idle
            assign left  = '0;
            assign right = '0;
        end

        tsum_lane #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .add_i   (lane_en[j]),
            .word_i  (vec_i[j*DATA_W +: DATA_W]),
            .left_i  (left),
            .right_i (right),
            .slot_o  (slot[j])
        );
    end

    tsum_store #(
        .ACC_W (ACC_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_i (store),
        .head_i  (slot[0]),
        .total_o (total_o),
        .done_o  (done_o)
    );

endmodule

// File: rtl/tsum_checker.sv
module tsum_checker #(
    parameter int N     = 8,
    parameter int LOG_N = 3,
    parameter int ACC_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [ACC_W-1:0] total_o
);

    localparam int CNT_W = $clog2(LOG_N + 3) + 1;
    localparam logic [CNT_W-1:0] JOB_STEPS = CNT_W'(LOG_N + 2);

    logic [CNT_W-1:0] steps_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_q <= '0;
        end else if (!busy_o && start_i) begin
            steps_q <= CNT_W'(1);
        end else if (busy_o) begin
            steps_q <= steps_q + CNT_W'(1);
        end
    end

    // R4: completion arrives exactly 2+log2(N) edges after acceptance
    p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (steps_q == JOB_STEPS));

    // R4: done is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: done follows a busy period
    p_busy_before_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    // R6: a job only begins from an accepted start
    p_busy_from_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R7: the total moves only together with done
    p_total_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(total_o) |-> done_o);

endmodule

bind tree_sum_engine tsum_checker #(
    .N     (N),
    .LOG_N (LOG_N),
    .ACC_W (ACC_W)
) u_tsum_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .total_o (total_o)
);

// File: tb/tb_tree_sum_engine.sv
module tb_tree_sum_engine;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int DATA_W     = 16;
    localparam int LOG_N      = $clog2(N);
    localparam int ACC_W      = DATA_W + LOG_N;
    localparam int WATCHDOG   = 20000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [N*DATA_W-1:0] vec = '0;
    logic                busy, done;
    logic [ACC_W-1:0]    total;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    // behavioural reference state
    int     m_cnt = 0;
    longint m_pend = 0;
    longint m_total = 0;
    bit     m_done = 0;

    tree_sum_engine #(.N(N), .DATA_W(DATA_W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .vec_i   (vec),
        .busy_o  (busy),
        .done_o  (done),
        .total_o (total)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint ref_sum(logic [N*DATA_W-1:0] v);
        longint s = 0;
        for (int k = 0; k < N; k++) s += longint'(v[k*DATA_W +: DATA_W]);
        return s;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // reference model: counts the job steps, samples the vector on acceptance
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_total = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_cnt == 0) begin
                if (start) begin
                    m_pend = ref_sum(vec);
                    m_cnt = 1;
                end
            end else begin
                m_cnt++;
                if (m_cnt == LOG_N + 2) begin
                    m_total = m_pend;
                    m_done = 1;
                    m_cnt = 0;
                end
            end
        end
        if (cyc > WATCHDOG && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            summary();
        end
    end

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == (m_cnt != 0), "R5 busy", longint'(busy), longint'(m_cnt != 0));
            check(done == m_done, "R4 done", longint'(done), longint'(m_done));
            check(longint'(total) == m_total, m_done ? "R3 total" : "R7 total held",
                  longint'(total), m_total);
        end
    end

    function automatic logic [N*DATA_W-1:0] rand_vec();
        logic [N*DATA_W-1:0] v;
        for (int k = 0; k < N; k++) v[k*DATA_W +: DATA_W] = DATA_W'($urandom);
        return v;
    endfunction

    // start a job, return the cycle stamp of the negedge that raised start
    task automatic launch(logic [N*DATA_W-1:0] v, output int c0);
        vec = v;
        start = 1'b1;
        c0 = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_job(logic [N*DATA_W-1:0] v, string tag);
        int c0;
        longint exp;
        exp = ref_sum(v);
        @(negedge clk);
        launch(v, c0);
        wait_done();
        check(cyc - c0 == LOG_N + 2, {tag, " R4 latency"}, cyc - c0, LOG_N + 2);
        check(longint'(total) == exp, {tag, " R3 sum"}, longint'(total), exp);
    endtask

    initial begin
        logic [N*DATA_W-1:0] v1, v2;
        int c0;
        longint exp1;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy in reset", longint'(busy), 0);
        check(done == 1'b0, "R1 done in reset", longint'(done), 0);
        check(total == '0, "R1 total in reset", longint'(total), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(total == '0 && !busy, "R1 after release", longint'(total), 0);

        // R3: distinct patterns
        run_job('0, "zeros");
        run_job({N*DATA_W{1'b1}}, "all-ones");
        for (int k = 0; k < N; k++) v1[k*DATA_W +: DATA_W] = DATA_W'(k + 1);
        run_job(v1, "ascending");
        v1 = '0; v1[(N-1)*DATA_W +: DATA_W] = '1;
        run_job(v1, "last-only");

        // R2: vector changes right after acceptance
        v1 = rand_vec(); v2 = rand_vec();
        exp1 = ref_sum(v1);
        @(negedge clk);
        launch(v1, c0);
        vec = v2;
        wait_done();
        check(longint'(total) == exp1, "R2 late vector ignored", longint'(total), exp1);

        // R6: repeated start during the rounds with a new vector
        v1 = rand_vec(); v2 = {N*DATA_W{1'b1}};
        exp1 = ref_sum(v1);
        @(negedge clk);
        launch(v1, c0);
        vec = v2; start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        wait_done();
        check(cyc - c0 == LOG_N + 2, "R6 timing kept", cyc - c0, LOG_N + 2);
        check(longint'(total) == exp1, "R6 result kept", longint'(total), exp1);
        repeat (LOG_N + 3) @(negedge clk);
        check(busy == 1'b0, "R6 no second job", longint'(busy), 0);

        // R7: total held during an idle gap
        exp1 = longint'(total);
        repeat (6) @(negedge clk);
        check(longint'(total) == exp1, "R7 idle hold", longint'(total), exp1);

        // R8: back-to-back jobs issued from the done cycle
        v1 = rand_vec();
        run_job(v1, "b2b first");
        v2 = rand_vec();
        exp1 = ref_sum(v2);
        launch(v2, c0);
        wait_done();
        check(cyc - c0 == LOG_N + 2, "R8 back-to-back latency", cyc - c0, LOG_N + 2);
        check(longint'(total) == exp1, "R8 back-to-back sum", longint'(total), exp1);

        // random vectors
        for (int t = 0; t < 25; t++) run_job(rand_vec(), "random");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule